// File: doc/BRIEF.md
# Input-Tree Reuse Test Engine

This block decides whether a code region that is about to be entered can be skipped because the same inputs were seen before. Past input sets are kept as ordered chains of address/value tuples. Chains that begin the same way share their first entries and fork where a later value differs, so together they form a tree. Every tree node is one entry of a ternary match array. An entry's key is the index of its parent node joined with a value, and a mask marks which bytes of that value are compared. A companion word for each entry holds a payload and an end flag. For an inner node the payload is the address the core must read next. For a leaf it is the index of the stored outputs.

The core starts a lookup with the region start address and then supplies one input value per step. Each step answers one cycle later with one of three results: read the next address, full hit with an output index, or miss. On a full hit the caller reuses the stored outputs and skips the region. On a miss the region runs normally. Insertions add one node per request. A node is given its parent index (the matched node index reported by a lookup, or the root code), and entries are allocated in ascending order until the array is full.

Top module: `tcam_reuse_test`

## Requirements
- R1: After reset `res_valid_o` and `ins_done_o` are 0, `res_kind_o` is 2'b00, and the array holds no entry, so any lookup misses.
- R2: A step with `step_first_i`=1 matches only entries whose parent field is all ones (63 for the default 32 entries) and whose value matches `step_val_i`.
- R3: A step with `step_first_i`=0 matches only entries whose parent field equals the index of the entry matched by the previous successful step.
- R4: Bit i of an entry's byte mask set to 1 means byte i (bits 8i+7..8i) of the value is compared. Set to 0, that byte is ignored.
- R5: On a match `res_idx_o` is the matched index and `res_addr_o` is the stored payload. `res_kind_o` is 2'b10 (hit) when the end flag is set, and `res_out_o` then carries the payload's low 8 bits. Otherwise `res_kind_o` is 2'b01 (next address).
- R6: When no valid entry matches, `res_kind_o` is 2'b11 (miss) and `res_idx_o`, `res_addr_o` and `res_out_o` are 0.
- R7: When several entries match, the lowest index wins.
- R8: Each insert is acknowledged one cycle later on `ins_done_o`. Accepted inserts take indices 0, 1, 2 and so on, in order, and the index is reported on `ins_idx_o` with `ins_ok_o`=1.
- R9: An insert into a full array returns `ins_ok_o`=0 and `ins_idx_o`=0, and every existing entry still looks up as before.
- R10: A step answers exactly one cycle later with `res_valid_o`=1. In any cycle that follows no step, `res_valid_o` is 0 and `res_kind_o` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_valid_i | input | 1 | Lookup step request |
| step_first_i | input | 1 | Step is the root step (value is the region start address) |
| step_val_i | input | 32 | Input value for this step |
| res_valid_o | output | 1 | Step result present |
| res_kind_o | output | 2 | 00 idle, 01 next address, 10 hit, 11 miss |
| res_idx_o | output | 5 | Matched entry index |
| res_addr_o | output | 32 | Payload of the matched entry (next address to read) |
| res_out_o | output | 8 | Output index on a hit |
| ins_valid_i | input | 1 | Insert request |
| ins_parent_i | input | 6 | Parent index of the new node, all ones for a root |
| ins_val_i | input | 32 | Value of the new node |
| ins_bmask_i | input | 4 | Byte compare mask of the new node |
| ins_end_i | input | 1 | New node is a leaf |
| ins_data_i | input | 32 | Payload of the new node |
| ins_done_o | output | 1 | Insert acknowledge |
| ins_ok_o | output | 1 | Insert accepted |
| ins_idx_o | output | 5 | Index allocated to the insert |

## Verification
A wrong parent chain, mask or priority inside the array shows up at the ports as a wrong `res_kind_o` or `res_idx_o` on the cycle after the step that touches the bad entry. A stale cursor shows up at the first non-root step of the next chain. A broken allocation counter shows up on the very next insert acknowledge as a wrong index or a wrong accept flag. Corruption caused by an insert into a full array stays hidden until a lookup walks over the damaged entry, so a known chain is walked again after the array fills.

// File: rtl/tcam_reuse_pkg.sv
// Shared types for the input-tree reuse test engine.
// Assumes: result kinds are a 2-bit code seen directly at the ports.
package tcam_reuse_pkg;
    typedef enum logic [1:0] {
        RES_IDLE = 2'b00,
        RES_NEXT = 2'b01,
        RES_HIT  = 2'b10,
        RES_MISS = 2'b11
    } res_kind_e;

    // Expand a per-byte compare mask into a per-bit mask.
    function automatic logic [31:0] byte_to_bit_mask(input logic [3:0] bm);
        logic [31:0] m;
        for (int b = 0; b < 4; b++) m[b*8 +: 8] = {8{bm[b]}};
        return m;
    endfunction
endpackage

// File: rtl/tcam_match_array.sv
// Ternary match array: each entry stores a parent index, a value and a
// byte compare mask. Produces a match vector for a {parent, value} key.
// Assumes: at most one write per cycle; writes are visible from the next cycle.
module tcam_match_array #(
    parameter int ENTRIES = 32,
    parameter int VAL_W   = 32,
    parameter int PAR_W   = 6,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int BYTES  = VAL_W / 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [PAR_W-1:0]   wr_parent,
    input  logic [VAL_W-1:0]   wr_val,
    input  logic [BYTES-1:0]   wr_bmask,
    input  logic [PAR_W-1:0]   key_parent,
    input  logic [VAL_W-1:0]   key_val,
    output logic [ENTRIES-1:0] match_vec
);
    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        logic             vld_q;
        logic [PAR_W-1:0] par_q;
        logic [VAL_W-1:0] val_q;
        logic [VAL_W-1:0] care_q;

        // Capture the entry key and its expanded care mask on a write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q  <= 1'b0;
                par_q  <= '0;
                val_q  <= '0;
                care_q <= '0;
            end else if (wr_en && wr_idx == IDX_W'(e)) begin
                vld_q  <= 1'b1;
                par_q  <= wr_parent;
                val_q  <= wr_val;
                for (int b = 0; b < BYTES; b++) care_q[b*8 +: 8] <= {8{wr_bmask[b]}};
            end
        end

        // Compare the key against this entry, ignoring don't-care bytes.
        always_comb begin
            match_vec[e] = vld_q && (par_q == key_parent) &&
                           (((val_q ^ key_val) & care_q) == '0);
        end
    end
endmodule

// File: rtl/tcam_prio_enc.sv
// Lowest-index priority encoder over a match vector.
// Assumes: index 0 has the highest priority.
module tcam_prio_enc #(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] vec,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);
    // Scan from the top down so the lowest set bit is written last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tcam_alloc.sv
// In-order entry allocator: grants indices 0..ENTRIES-1 once each.
// Assumes: entries are never freed.
module tcam_alloc #(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    output logic             grant,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W:0] used_q;

    // Grant only while entries remain.
    always_comb begin
        grant = req && (used_q < (IDX_W+1)'(ENTRIES));
        idx   = used_q[IDX_W-1:0];
    end

    // Count granted entries.
    always_ff @(posedge clk) begin
        if (!rst_n)     used_q <= '0;
        else if (grant) used_q <= used_q + 1'b1;
    end
endmodule

// File: rtl/tcam_reuse_test.sv
// Reuse test engine: walks an input tree stored in a ternary match array,
// one input value per cycle, and reports next address, hit or miss.
// Assumes: the caller supplies parent indices on insert; lookups see the
// table as it stood before any insert in the same cycle.
module tcam_reuse_test #(
    parameter int ENTRIES = 32,
    parameter int VAL_W   = 32,
    parameter int ADDR_W  = 32,
    parameter int OUT_W   = 8,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int PAR_W  = IDX_W + 1,
    localparam int BYTES  = VAL_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_valid_i,
    input  logic              step_first_i,
    input  logic [VAL_W-1:0]  step_val_i,
    output logic              res_valid_o,
    output logic [1:0]        res_kind_o,
    output logic [IDX_W-1:0]  res_idx_o,
    output logic [ADDR_W-1:0] res_addr_o,
    output logic [OUT_W-1:0]  res_out_o,
    input  logic              ins_valid_i,
    input  logic [PAR_W-1:0]  ins_parent_i,
    input  logic [VAL_W-1:0]  ins_val_i,
    input  logic [BYTES-1:0]  ins_bmask_i,
    input  logic              ins_end_i,
    input  logic [ADDR_W-1:0] ins_data_i,
    output logic              ins_done_o,
    output logic              ins_ok_o,
    output logic [IDX_W-1:0]  ins_idx_o
);
    import tcam_reuse_pkg::*;

    localparam logic [PAR_W-1:0] ROOT_PAR = {PAR_W{1'b1}};

    logic               grant;
    logic [IDX_W-1:0]   alloc_idx;
    logic [ENTRIES-1:0] match_vec;
    logic               found;
    logic [IDX_W-1:0]   hit_idx;
    logic [PAR_W-1:0]   key_parent;
    logic [IDX_W-1:0]   cursor_q;
    logic [ADDR_W-1:0]  ram_data [ENTRIES];
    logic [ENTRIES-1:0] ram_end;

    tcam_alloc #(.ENTRIES(ENTRIES)) u_alloc (
        .clk(clk), .rst_n(rst_n), .req(ins_valid_i), .grant(grant), .idx(alloc_idx)
    );

    // Root steps key on the all-ones parent; later steps on the cursor.
    always_comb key_parent = step_first_i ? ROOT_PAR : {1'b0, cursor_q};

    tcam_match_array #(.ENTRIES(ENTRIES), .VAL_W(VAL_W), .PAR_W(PAR_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .wr_en(grant), .wr_idx(alloc_idx), .wr_parent(ins_parent_i),
        .wr_val(ins_val_i), .wr_bmask(ins_bmask_i),
        .key_parent(key_parent), .key_val(step_val_i), .match_vec(match_vec)
    );

    tcam_prio_enc #(.ENTRIES(ENTRIES)) u_prio (
        .vec(match_vec), .found(found), .idx(hit_idx)
    );

    // Companion payload store, written alongside the match entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_end <= '0;
            for (int i = 0; i < ENTRIES; i++) ram_data[i] <= '0;
        end else if (grant) begin
            ram_end[alloc_idx]  <= ins_end_i;
            ram_data[alloc_idx] <= ins_data_i;
        end
    end

    // Register each step result and advance the cursor on a match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid_o <= 1'b0;
            res_kind_o  <= RES_IDLE;
            res_idx_o   <= '0;
            res_addr_o  <= '0;
            res_out_o   <= '0;
            cursor_q    <= '0;
        end else begin
            res_valid_o <= step_valid_i;
            res_kind_o  <= RES_IDLE;
            res_idx_o   <= '0;
            res_addr_o  <= '0;
            res_out_o   <= '0;
            if (step_valid_i) begin
                if (found) begin
                    res_kind_o <= ram_end[hit_idx] ? RES_HIT : RES_NEXT;
                    res_idx_o  <= hit_idx;
                    res_addr_o <= ram_data[hit_idx];
                    res_out_o  <= ram_end[hit_idx] ? ram_data[hit_idx][OUT_W-1:0] : '0;
                    cursor_q   <= hit_idx;
                end else begin
                    res_kind_o <= RES_MISS;
                end
            end
        end
    end

    // Acknowledge each insert with its allocated index or a rejection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ins_done_o <= 1'b0;
            ins_ok_o   <= 1'b0;
            ins_idx_o  <= '0;
        end else begin
            ins_done_o <= ins_valid_i;
            ins_ok_o   <= grant;
            ins_idx_o  <= grant ? alloc_idx : '0;
        end
    end
endmodule

// File: rtl/tcam_reuse_test_chk.sv
// Protocol checker for the reuse test engine, bound to the top module.
// Assumes: synchronous active-low reset; tracks accepted inserts itself.
module tcam_reuse_test_chk #(
    parameter int ENTRIES = 32,
    parameter int IDX_W   = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             step_valid_i,
    input logic             res_valid_o,
    input logic [1:0]       res_kind_o,
    input logic [IDX_W-1:0] res_idx_o,
    input logic             ins_valid_i,
    input logic             ins_done_o,
    input logic             ins_ok_o,
    input logic [IDX_W-1:0] ins_idx_o
);
    logic [IDX_W:0] ok_cnt;

    // Count accepted inserts as seen at the acknowledge port.
    always_ff @(posedge clk) begin
        if (!rst_n)        ok_cnt <= '0;
        else if (ins_ok_o) ok_cnt <= ok_cnt + 1'b1;
    end

    assert_step_answer_R10: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid_i |=> res_valid_o);
    assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !step_valid_i |=> (!res_valid_o && res_kind_o == 2'b00));
    assert_empty_miss_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && ok_cnt == '0) |-> res_kind_o == 2'b11);
    assert_kind_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> res_kind_o != 2'b00);
    assert_miss_idx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && res_kind_o == 2'b11) |-> res_idx_o == '0);
    assert_ins_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid_i |=> ins_done_o);
    assert_in_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ins_ok_o |-> ins_idx_o == ok_cnt[IDX_W-1:0]);
    assert_full_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_done_o && ok_cnt == (IDX_W+1)'(ENTRIES)) |-> !ins_ok_o);
endmodule

bind tcam_reuse_test tcam_reuse_test_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .step_valid_i(step_valid_i),
    .res_valid_o(res_valid_o), .res_kind_o(res_kind_o), .res_idx_o(res_idx_o),
    .ins_valid_i(ins_valid_i), .ins_done_o(ins_done_o), .ins_ok_o(ins_ok_o),
    .ins_idx_o(ins_idx_o)
);

// File: tb/tcam_reuse_test_tb.sv
// Self-checking bench: directed tree cases plus seeded random inserts and
// lookups, compared against a bench-side model of the entry table.
module tcam_reuse_test_tb;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_valid_i = 1'b0, step_first_i = 1'b0;
    logic [31:0] step_val_i = '0;
    logic        res_valid_o;
    logic [1:0]  res_kind_o;
    logic [4:0]  res_idx_o;
    logic [31:0] res_addr_o;
    logic [7:0]  res_out_o;
    logic        ins_valid_i = 1'b0;
    logic [5:0]  ins_parent_i = '0;
    logic [31:0] ins_val_i = '0;
    logic [3:0]  ins_bmask_i = '0;
    logic        ins_end_i = 1'b0;
    logic [31:0] ins_data_i = '0;
    logic        ins_done_o, ins_ok_o;
    logic [4:0]  ins_idx_o;

    int checks = 0, errors = 0;
    int m_cnt = 0, cur = 0;
    int          m_par  [N];
    logic [31:0] m_val  [N];
    logic [3:0]  m_mask [N];
    logic        m_end  [N];
    logic [31:0] m_data [N];

    always #10 clk = ~clk;

    tcam_reuse_test u_dut (.*);

    function automatic logic [31:0] bits_of(input logic [3:0] bm);
        logic [31:0] m;
        for (int b = 0; b < 4; b++) m[b*8 +: 8] = {8{bm[b]}};
        return m;
    endfunction

    function automatic int mdl_find(input int par, input logic [31:0] v);
        for (int i = 0; i < m_cnt; i++)
            if (m_par[i] == par && ((m_val[i] ^ v) & bits_of(m_mask[i])) == 0) return i;
        return -1;
    endfunction

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_insert(input int par, input logic [31:0] v, input logic [3:0] bm,
                             input logic e, input logic [31:0] d, input string req);
        logic ok;
        ok = (m_cnt < N);
        ins_valid_i = 1'b1; ins_parent_i = 6'(par); ins_val_i = v;
        ins_bmask_i = bm; ins_end_i = e; ins_data_i = d;
        @(negedge clk);
        ins_valid_i = 1'b0;
        chk(req, {41'd0, ins_done_o, ins_ok_o, ins_idx_o},
                 {41'd0, 1'b1, ok, ok ? 5'(m_cnt) : 5'd0});
        if (ok) begin
            m_par[m_cnt] = par; m_val[m_cnt] = v; m_mask[m_cnt] = bm;
            m_end[m_cnt] = e; m_data[m_cnt] = d; m_cnt++;
        end
    endtask

    task automatic do_step(input logic first, input logic [31:0] v, input string req);
        int hit;
        logic [47:0] exp;
        hit = mdl_find(first ? 63 : cur, v);
        step_valid_i = 1'b1; step_first_i = first; step_val_i = v;
        @(negedge clk);
        step_valid_i = 1'b0;
        if (hit < 0) exp = {1'b1, 2'b11, 5'd0, 32'd0, 8'd0};
        else begin
            exp = {1'b1, m_end[hit] ? 2'b10 : 2'b01, 5'(hit), m_data[hit],
                   m_end[hit] ? m_data[hit][7:0] : 8'd0};
            cur = hit;
        end
        chk(req, {res_valid_o, res_kind_o, res_idx_o, res_addr_o, res_out_o}, exp);
    endtask

    task automatic walk_a(input string req);
        do_step(1'b1, 32'h0000_1000, req);
        do_step(1'b0, 32'h1122_3344, req);
        do_step(1'b0, 32'hABCD_EF55, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7331));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset", {44'd0, res_valid_o, res_kind_o, ins_done_o},
                        {44'd0, 1'b0, 2'b00, 1'b0});
        rst_n = 1'b1;
        @(negedge clk);
        do_step(1'b1, 32'h0000_1000, "R1 R6 empty table miss");
        // R10: no step -> idle
        @(negedge clk);
        chk("R10 idle after step", {45'd0, res_valid_o, res_kind_o}, 48'd0);
        // R8: in-order allocation of chain A
        do_insert(63, 32'h0000_1000, 4'hF, 1'b0, 32'h200, "R8 root insert");
        do_insert(0, 32'h1122_3344, 4'hF, 1'b0, 32'h204, "R8 child insert");
        do_insert(1, 32'h0000_0055, 4'h1, 1'b1, 32'h7, "R8 leaf insert");
        do_insert(1, 32'h0000_0066, 4'h1, 1'b1, 32'h9, "R8 branch insert");
        // R2 R3 R4 R5: walk chain A to a hit through a byte-masked leaf
        do_step(1'b1, 32'h0000_1000, "R2 root match");
        do_step(1'b0, 32'h1122_3344, "R3 R5 chained next");
        do_step(1'b0, 32'hABCD_EF55, "R4 R5 masked leaf hit");
        // Branch of the shared prefix
        do_step(1'b1, 32'h0000_1000, "R2 root again");
        do_step(1'b0, 32'h1122_3344, "R3 chained");
        do_step(1'b0, 32'h0000_0166, "R4 branch leaf hit");
        // R7: don't-care entry overlaps entry 1
        do_insert(0, 32'h0, 4'h0, 1'b1, 32'h3, "R8 wildcard insert");
        do_step(1'b1, 32'h0000_1000, "R7 root");
        do_step(1'b0, 32'h1122_3344, "R7 lowest index wins");
        do_step(1'b1, 32'h0000_1000, "R7 root");
        do_step(1'b0, 32'h9999_9999, "R7 wildcard only");
        // R3: cursor from another root must not reach entry 1
        do_insert(63, 32'h0000_2000, 4'hF, 1'b0, 32'h300, "R8 second root");
        do_step(1'b1, 32'h0000_2000, "R3 other root");
        do_step(1'b0, 32'h1122_3344, "R3 wrong parent miss");
        // R6: root miss
        do_step(1'b1, 32'h0000_3000, "R6 unknown region miss");
        // Random fill and lookups
        while (m_cnt < N) begin
            int par;
            par = ($urandom % 4 == 0) ? 63 : int'($urandom % m_cnt);
            do_insert(par, $urandom, 4'($urandom), 1'($urandom), $urandom, "R8 random insert");
        end
        for (int k = 0; k < 60; k++) begin
            int j;
            logic [31:0] v;
            j = int'($urandom % m_cnt);
            v = ($urandom % 4 == 0) ? $urandom
              : (($urandom % 2) ? m_val[j] : m_val[j] ^ (32'hFF << (8 * ($urandom % 4))));
            do_step(($urandom % 3) == 0, v, "R3 R4 R7 random lookup");
        end
        // R9: full table rejects and keeps contents
        do_insert(63, 32'h0000_1000, 4'hF, 1'b1, 32'h1, "R9 full reject");
        walk_a("R9 chain intact");
        @(negedge clk);
        chk("R10 idle at end", {45'd0, res_valid_o, res_kind_o}, 48'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule